// File: doc/BRIEF.md
# Pipeline Exception Control Unit

This block steers a five-stage pipeline when one of two faults appears: an opcode the decoder does not recognise, flagged in the decode stage, or an arithmetic overflow, flagged in the execute stage. In the same cycle that a fault is accepted, it loads fetch with a handler address. It also clears the pipeline registers that hold the faulting instruction and every younger one. Older instructions, already past the faulting stage, still retire. The execute-stage register-write enable goes through this block, so an overflowing instruction never writes its destination.

On entry, the block stores the faulting instruction's PC in an exception-PC register and a one-bit cause code in a cause register. Handler software reads both back through a small select-and-read port. A mode pin chooses between two kinds of handler entry. In the first, every fault goes to one fixed entry and the handler reads the cause. In the second, the entry address is a base plus the cause times a fixed stride, so each cause has its own entry.

A two-state machine governs acceptance. In RUN, faults are taken. Entry moves it to SETTLE, where it stays for a parameterised number of cycles and ignores the fault flags, because the stages are holding bubbles. It then returns to RUN. Transitions: RUN→SETTLE on an accepted fault, SETTLE→SETTLE while the settle count is above one, SETTLE→RUN when the count reaches one.

Top module: `exc_ctrl`

## Requirements
- R1: When an overflow is flagged in RUN, `pc_load` is 1 in that same cycle, `flush_ifid`, `flush_idex` and `flush_exmem` are all 1, and `ex_wen_o` is 0 whatever `ex_wen_i` is.
- R2: When only an undefined opcode is flagged in RUN, `pc_load`, `flush_ifid` and `flush_idex` are 1, `flush_exmem` is 0, and `ex_wen_o` equals `ex_wen_i`, so the older execute-stage instruction completes.
- R3: When both flags are set in the same RUN cycle, the overflow wins: all three flushes are 1, `ex_wen_o` is 0, and the stored PC and cause are those of the execute-stage instruction.
- R4: From the cycle after entry, reading with `rd_sel`=0 returns the faulting instruction's PC: `ex_pc` for an overflow, `id_pc` for an undefined opcode.
- R5: From the cycle after entry, reading with `rd_sel`=1 returns the cause in bit 0 (0 = undefined opcode, 1 = overflow), with every other bit 0.
- R6: With `vec_mode`=0, `pc_target` is 0x8000_0180 for both causes when `pc_load` is 1.
- R7: With `vec_mode`=1, `pc_target` is 0xC000_0000 for an undefined opcode and 0xC000_0020 for an overflow when `pc_load` is 1.
- R8: In a cycle with no flag set, `pc_load` and all flushes are 0, `ex_wen_o` equals `ex_wen_i`, and the stored PC and cause keep their values.
- R9: For SETTLE_LEN cycles after an entry (2 by default), both flags are ignored: `pc_load` and the flushes stay 0, `ex_wen_o` follows `ex_wen_i`, and the stored values do not change. In the following cycle a fault is accepted again.
- R10: After reset, the stored PC and cause read as 0, and a fault is accepted in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_mode | input | 1 | 0: single fixed handler entry, 1: per-cause entries |
| id_undef | input | 1 | Decode stage holds an undefined opcode |
| id_pc | input | XLEN | PC of the decode-stage instruction |
| ex_ovf | input | 1 | Execute stage produced an arithmetic overflow |
| ex_pc | input | XLEN | PC of the execute-stage instruction |
| ex_wen_i | input | 1 | Register-write enable of the execute-stage instruction |
| ex_wen_o | output | 1 | Write enable passed on to the execute/memory register |
| flush_ifid | output | 1 | Clear the fetch/decode pipeline register |
| flush_idex | output | 1 | Clear the decode/execute pipeline register |
| flush_exmem | output | 1 | Clear the execute/memory pipeline register |
| pc_load | output | 1 | Load the fetch PC with `pc_target` |
| pc_target | output | XLEN | Handler entry address |
| rd_sel | input | 1 | Read select: 0 stored PC, 1 cause |
| rd_data | output | XLEN | Read data for the handler |

## Verification
The bench uses the default parameters: 32-bit PCs, fixed entry 0x8000_0180, vector base 0xC000_0000 with a 0x20 stride, and a settle window of two cycles. These values make both entry addresses in each mode directly checkable. The short window lets the bench place a fault on each ignored cycle and on the first re-armed cycle within a few clocks. A table walk covers each cause alone and both causes together in each mode, and a no-fault cycle that must leave the stored values unchanged.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic {
        CAUSE_UNDEF = 1'b0,
        CAUSE_OVF   = 1'b1
    } cause_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_SETTLE = 1'b1
    } exc_state_e;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            accept,
    input  logic            id_undef,
    input  logic [XLEN-1:0] id_pc,
    input  logic            ex_ovf,
    input  logic [XLEN-1:0] ex_pc,
    output logic            hit,
    output cause_e          cause,
    output logic [XLEN-1:0] src_pc,
    output logic            kill_if,
    output logic            kill_id,
    output logic            kill_ex
);

    logic take_ovf;
    logic take_undef;

    // the older stage (execute) has priority over decode
    assign take_ovf   = accept & ex_ovf;
    assign take_undef = accept & id_undef & ~ex_ovf;

    always_comb begin
        hit     = take_ovf | take_undef;
        cause   = take_ovf ? CAUSE_OVF : CAUSE_UNDEF;
        src_pc  = take_ovf ? ex_pc : id_pc;
        kill_if = take_ovf | take_undef;
        kill_id = take_ovf | take_undef;
        kill_ex = take_ovf;
    end

endmodule

// File: rtl/exc_vector.sv
module exc_vector
    import exc_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter logic [XLEN-1:0] FIXED_ENTRY = 32'h8000_0180,
    parameter logic [XLEN-1:0] VEC_BASE    = 32'hC000_0000,
    parameter logic [XLEN-1:0] VEC_STRIDE  = 32'h0000_0020
) (
    input  logic            vec_mode,
    input  cause_e          cause,
    output logic [XLEN-1:0] target
);

    logic [XLEN-1:0] vec_addr;

    assign vec_addr = VEC_BASE + (cause == CAUSE_OVF ? VEC_STRIDE : '0);
    assign target   = vec_mode ? vec_addr : FIXED_ENTRY;

endmodule

// File: rtl/exc_regs.sv
module exc_regs
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  cause_e          cause_in,
    input  logic [XLEN-1:0] pc_in,
    input  logic            rd_sel,
    output logic [XLEN-1:0] epc_q,
    output cause_e          cause_q,
    output logic [XLEN-1:0] rd_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= CAUSE_UNDEF;
        end else if (capture) begin
            epc_q   <= pc_in;
            cause_q <= cause_in;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel) rd_data[0] = cause_q;
        else        rd_data    = epc_q;
    end

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
    import exc_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter logic [XLEN-1:0] FIXED_ENTRY = 32'h8000_0180,
    parameter logic [XLEN-1:0] VEC_BASE    = 32'hC000_0000,
    parameter logic [XLEN-1:0] VEC_STRIDE  = 32'h0000_0020,
    parameter int              SETTLE_LEN  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vec_mode,
    input  logic            id_undef,
    input  logic [XLEN-1:0] id_pc,
    input  logic            ex_ovf,
    input  logic [XLEN-1:0] ex_pc,
    input  logic            ex_wen_i,
    output logic            ex_wen_o,
    output logic            flush_ifid,
    output logic            flush_idex,
    output logic            flush_exmem,
    output logic            pc_load,
    output logic [XLEN-1:0] pc_target,
    input  logic            rd_sel,
    output logic [XLEN-1:0] rd_data
);

    localparam int CW = (SETTLE_LEN < 2) ? 1 : $clog2(SETTLE_LEN + 1);

    exc_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            accept;
    logic            hit;
    cause_e          sel_cause;
    logic [XLEN-1:0] sel_pc;
    logic            kill_if, kill_id, kill_ex;
    logic [XLEN-1:0] epc_q;
    cause_e          cause_q;

    exc_arbiter #(.XLEN(XLEN)) u_arb (
        .accept  (accept),
        .id_undef(id_undef),
        .id_pc   (id_pc),
        .ex_ovf  (ex_ovf),
        .ex_pc   (ex_pc),
        .hit     (hit),
        .cause   (sel_cause),
        .src_pc  (sel_pc),
        .kill_if (kill_if),
        .kill_id (kill_id),
        .kill_ex (kill_ex)
    );

    exc_vector #(
        .XLEN       (XLEN),
        .FIXED_ENTRY(FIXED_ENTRY),
        .VEC_BASE   (VEC_BASE),
        .VEC_STRIDE (VEC_STRIDE)
    ) u_vec (
        .vec_mode(vec_mode),
        .cause   (sel_cause),
        .target  (pc_target)
    );

    exc_regs #(.XLEN(XLEN)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (hit),
        .cause_in(sel_cause),
        .pc_in   (sel_pc),
        .rd_sel  (rd_sel),
        .epc_q   (epc_q),
        .cause_q (cause_q),
        .rd_data (rd_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (hit) begin
                    state_d = ST_SETTLE;
                    cnt_d   = CW'(SETTLE_LEN);
                end
            end
            ST_SETTLE: begin
                if (cnt_q <= CW'(1)) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            default: begin
                state_d = ST_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        accept      = 1'b0;
        unique case (state_q)
            ST_RUN:    accept = 1'b1;
            ST_SETTLE: accept = 1'b0;
            default:   accept = 1'b0;
        endcase
        pc_load     = hit;
        flush_ifid  = kill_if;
        flush_idex  = kill_id;
        flush_exmem = kill_ex;
        ex_wen_o    = ex_wen_i & ~kill_ex;
    end

endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
    parameter int              XLEN        = 32,
    parameter logic [XLEN-1:0] FIXED_ENTRY = 32'h8000_0180
) (
    input logic            clk,
    input logic            rst_n,
    input logic            vec_mode,
    input logic            id_undef,
    input logic [XLEN-1:0] id_pc,
    input logic            ex_ovf,
    input logic [XLEN-1:0] ex_pc,
    input logic            ex_wen_i,
    input logic            ex_wen_o,
    input logic            flush_ifid,
    input logic            flush_idex,
    input logic            flush_exmem,
    input logic            pc_load,
    input logic [XLEN-1:0] pc_target,
    input logic [XLEN-1:0] epc_q,
    input logic            cause_q
);

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_OVF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && ex_ovf) |-> (flush_exmem && flush_idex && flush_ifid && !ex_wen_o)); // R1

    AST_UNDEF_KEEP_EX: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !ex_ovf) |-> (!flush_exmem && flush_idex && flush_ifid && ex_wen_o == ex_wen_i)); // R2

    AST_OVF_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && ex_ovf && id_undef) |=> (cause_q && epc_q == $past(ex_pc))); // R3

    AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !ex_ovf) |=> (epc_q == $past(id_pc) && !cause_q)); // R4

    AST_FIXED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !vec_mode) |-> (pc_target == FIXED_ENTRY)); // R6

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !pc_load) |=> ($stable(epc_q) && $stable(cause_q))); // R8

    AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load); // R9

    AST_FLUSH_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_ifid || flush_idex || flush_exmem) |-> pc_load); // R8

endmodule

bind exc_ctrl exc_ctrl_chk #(
    .XLEN       (XLEN),
    .FIXED_ENTRY(FIXED_ENTRY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vec_mode   (vec_mode),
    .id_undef   (id_undef),
    .id_pc      (id_pc),
    .ex_ovf     (ex_ovf),
    .ex_pc      (ex_pc),
    .ex_wen_i   (ex_wen_i),
    .ex_wen_o   (ex_wen_o),
    .flush_ifid (flush_ifid),
    .flush_idex (flush_idex),
    .flush_exmem(flush_exmem),
    .pc_load    (pc_load),
    .pc_target  (pc_target),
    .epc_q      (epc_q),
    .cause_q    (cause_q)
);

// File: tb/sim_exc_ctrl.sv
`timescale 1ns/1ps
module sim_exc_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vec_mode = 1'b0;
    logic        id_undef = 1'b0;
    logic [31:0] id_pc = '0;
    logic        ex_ovf = 1'b0;
    logic [31:0] ex_pc = '0;
    logic        ex_wen_i = 1'b0;
    logic        ex_wen_o;
    logic        flush_ifid, flush_idex, flush_exmem;
    logic        pc_load;
    logic [31:0] pc_target;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    exc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .vec_mode(vec_mode),
        .id_undef(id_undef), .id_pc(id_pc), .ex_ovf(ex_ovf), .ex_pc(ex_pc),
        .ex_wen_i(ex_wen_i), .ex_wen_o(ex_wen_o),
        .flush_ifid(flush_ifid), .flush_idex(flush_idex), .flush_exmem(flush_exmem),
        .pc_load(pc_load), .pc_target(pc_target),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    typedef struct packed {
        logic        ovf;
        logic        und;
        logic        vm;
        logic        wen;
        logic [31:0] expc;
        logic [31:0] idpc;
        logic        e_load;
        logic [2:0]  e_fl;     // {ifid, idex, exmem}
        logic        e_wen;
        logic [31:0] e_tgt;
        logic [31:0] e_epc;
        logic        e_cause;
    } vec_t;

    localparam vec_t VT [7] = '{
        '{1'b0,1'b1,1'b0,1'b1,32'h0FC,32'h100,1'b1,3'b110,1'b1,32'h8000_0180,32'h100,1'b0}, // R2 R6
        '{1'b1,1'b0,1'b0,1'b1,32'h204,32'h208,1'b1,3'b111,1'b0,32'h8000_0180,32'h204,1'b1}, // R1 R6
        '{1'b0,1'b1,1'b1,1'b1,32'h2FC,32'h300,1'b1,3'b110,1'b1,32'hC000_0000,32'h300,1'b0}, // R7
        '{1'b1,1'b0,1'b1,1'b1,32'h404,32'h408,1'b1,3'b111,1'b0,32'hC000_0020,32'h404,1'b1}, // R7
        '{1'b1,1'b1,1'b1,1'b1,32'h500,32'h504,1'b1,3'b111,1'b0,32'hC000_0020,32'h500,1'b1}, // R3
        '{1'b1,1'b1,1'b0,1'b0,32'h600,32'h604,1'b1,3'b111,1'b0,32'h8000_0180,32'h600,1'b1}, // R3
        '{1'b0,1'b0,1'b1,1'b1,32'h700,32'h704,1'b0,3'b000,1'b1,32'h0,        32'h600,1'b1}  // R8
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        ex_ovf = 0; id_undef = 0; ex_wen_i = 0;
    endtask

    task automatic read_back(input string req, input logic [31:0] e_epc, input logic e_cause);
        rd_sel = 1'b0; #1;
        chk({req, " epc"}, rd_data, e_epc);
        rd_sel = 1'b1; #1;
        chk({req, " cause"}, rd_data, {31'b0, e_cause});
        rd_sel = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset values
        read_back("R10", 32'h0, 1'b0);
        chk("R10 no load", {31'b0, pc_load}, 32'h0);

        // table walk
        for (int i = 0; i < 7; i++) begin
            @(posedge clk); #1;
            ex_ovf = VT[i].ovf; id_undef = VT[i].und; vec_mode = VT[i].vm;
            ex_wen_i = VT[i].wen; ex_pc = VT[i].expc; id_pc = VT[i].idpc;
            @(negedge clk);
            chk($sformatf("vec%0d R1/R2/R8 load", i), {31'b0, pc_load}, {31'b0, VT[i].e_load});
            chk($sformatf("vec%0d R1/R2/R3 flush", i), {29'b0, flush_ifid, flush_idex, flush_exmem}, {29'b0, VT[i].e_fl});
            chk($sformatf("vec%0d R1/R2 wen", i), {31'b0, ex_wen_o}, {31'b0, VT[i].e_wen});
            if (VT[i].e_load)
                chk($sformatf("vec%0d R6/R7 target", i), pc_target, VT[i].e_tgt);
            @(posedge clk); #1;
            idle();
            @(negedge clk);
            read_back($sformatf("vec%0d R4/R5", i), VT[i].e_epc, VT[i].e_cause);
            repeat (3) @(posedge clk);
        end

        // R9: faults during the settle window are ignored
        @(posedge clk); #1;
        id_undef = 1; id_pc = 32'h800; vec_mode = 0;
        @(posedge clk); #1;
        id_undef = 0; ex_ovf = 1; ex_pc = 32'h900; ex_wen_i = 1;
        @(negedge clk);
        chk("R9 settle1 load", {31'b0, pc_load}, 32'h0);
        chk("R9 settle1 flush", {29'b0, flush_ifid, flush_idex, flush_exmem}, 32'h0);
        chk("R9 settle1 wen", {31'b0, ex_wen_o}, 32'h1);
        @(posedge clk); #1;
        id_undef = 1; id_pc = 32'hA00;
        @(negedge clk);
        chk("R9 settle2 load", {31'b0, pc_load}, 32'h0);
        read_back("R9 settle2", 32'h800, 1'b0);
        @(posedge clk); #1;
        ex_ovf = 1; ex_pc = 32'hB00; id_undef = 0; ex_wen_i = 1;
        @(negedge clk);
        chk("R9 rearm load", {31'b0, pc_load}, 32'h1);
        chk("R1 rearm wen", {31'b0, ex_wen_o}, 32'h0);
        @(posedge clk); #1;
        idle();
        @(negedge clk);
        read_back("R9 rearm", 32'hB00, 1'b1);

        // R10: fault accepted in the first cycle after reset
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        ex_ovf = 1; ex_pc = 32'hC04; vec_mode = 1;
        @(negedge clk);
        chk("R10 first load", {31'b0, pc_load}, 32'h1);
        chk("R7 first target", pc_target, 32'hC000_0020);
        @(posedge clk); #1;
        idle();
        @(negedge clk);
        read_back("R10 first", 32'hC04, 1'b1);

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule